// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a slower next-level memory. It keeps 1024 single-word lines. Each line carries a valid flag, a modified flag and a tag. Loads and stores that find their word in the cache finish in the cycle they are presented. All other accesses stall the processor while a small controller runs the memory transfers. First it writes back a modified victim line, if there is one, and then it reads the requested word.

The policy is write-back with write-allocate. A store that hits changes only the cached copy and marks the line modified. A store that misses first reads the word from memory, then merges its enabled bytes into it, and leaves the line marked modified. Memory is written only when a modified line is evicted. The processor holds its request, address, data and byte enables stable for as long as the stall is high. The memory side uses a request that is held until a one-cycle acknowledge arrives.

Top module: `dm_wb_cache`

## Requirements
- R1: Reset clears every valid and modified flag. After reset, the first access to any address misses, and no victim is written back, even if the line was modified before the reset.
- R2: The address is split as follows: bits 1:0 are the byte offset and are ignored for lookup, bits 11:2 select one of 1024 lines, and bits 31:12 form the tag. Two addresses with the same index and different tags evict each other.
- R3: Each memory transfer raises mem_req and holds mem_req, mem_we, mem_addr and mem_wdata stable until the cycle in which mem_ack is high. mem_addr always has bits 1:0 equal to zero.
- R4: A read whose line is valid and whose stored tag equals the address tag keeps cpu_stall low in the same cycle. cpu_rdata then returns the stored word, and no memory transfer is started.
- R5: A miss whose victim is invalid or unmodified issues exactly one memory read, at the requested word address, and no memory write.
- R6: A miss whose victim is valid and modified first writes the victim word to the address formed from its stored tag and the index. Only then does it read the requested word.
- R7: A write hit updates byte i (bits 8i+7:8i) when cpu_be bit i is set, marks the line modified and causes no memory traffic.
- R8: A write miss allocates the line. It reads the word from memory, replaces the bytes enabled by cpu_be with cpu_wdata and leaves the line modified.
- R9: cpu_stall is high from the cycle the miss is seen through the cycle of the final mem_ack. In the next cycle the held request completes as a hit. With a memory that answers each request on the fourth cycle, a clean miss stalls for 5 cycles and a miss with write-back stalls for 9.
- R10: A line filled by a read miss is unmodified, so evicting it later causes no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables, bit i for byte i |
| cpu_rdata | output | 32 | Load data, valid when cpu_stall is low |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Next-level transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr | output | 32 | Word-aligned next-level address |
| mem_wdata | output | 32 | Victim word for write-back |
| mem_rdata | input | 32 | Fill data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle transfer completion |

## Verification
Embedded properties check on every cycle the following:
- the memory request stays stable until it is acknowledged;
- only a modified, valid victim is ever written back;
- every acknowledged write-back is followed by a fill to the same index;
- a completed fill lets the held request finish without a stall;
- a non-stalled access never coincides with memory traffic.

Only the directed scenarios can show the data side:
- the returned words;
- byte-enable merging on write hits and write misses;
- the exact stall lengths;
- the victim address and data;
- the clean state of read-filled lines;
- the loss of modified lines across a reset.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FILL  = 2'd2
   } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 2,
   parameter int IDX_W  = 10,
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  tag
);
   assign idx = addr[OFF_W +: IDX_W];
   assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/dmc_line_array.sv
module dmc_line_array #(
   parameter int IDX_W  = 10,
   parameter int TAG_W  = 20,
   parameter int DATA_W = 32,
   localparam int LINES = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_dirty
);
   logic [LINES-1:0]  valid_q;
   logic [LINES-1:0]  dirty_q;
   logic [TAG_W-1:0]  tag_mem  [LINES];
   logic [DATA_W-1:0] data_mem [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
         dirty_q[wr_idx] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_mem[wr_idx]  <= wr_tag;
         data_mem[wr_idx] <= wr_data;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_tag   = tag_mem[rd_idx];
   assign rd_data  = data_mem[rd_idx];
endmodule

// File: rtl/dmc_miss_fsm.sv
module dmc_miss_fsm
   import dmc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       miss_start,
   input  logic       victim_dirty,
   input  logic       mem_ack,
   output dmc_state_e state
);
   dmc_state_e state_d;

   always_comb begin
      state_d = state;
      unique case (state)
         ST_IDLE:  if (miss_start) state_d = victim_dirty ? ST_WBACK : ST_FILL;
         ST_WBACK: if (mem_ack)    state_d = ST_FILL;
         ST_FILL:  if (mem_ack)    state_d = ST_IDLE;
         default:                  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_d;
   end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
   import dmc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 10,
   localparam int BE_W  = DATA_W / 8,
   localparam int OFF_W = $clog2(BE_W),
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [BE_W-1:0]   cpu_be,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   if (DATA_W % 8 != 0 || (1 << OFF_W) != BE_W) begin : g_bad_width
      $error("dm_wb_cache: DATA_W must be a power-of-two number of bytes");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("dm_wb_cache: address too narrow for IDX_W");
   end

   logic [IDX_W-1:0]  idx;
   logic [TAG_W-1:0]  tag;
   logic              rd_valid, rd_dirty;
   logic [TAG_W-1:0]  rd_tag;
   logic [DATA_W-1:0] rd_data;
   logic              wr_en;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] base_word;
   logic [BE_W-1:0]   eff_be;
   dmc_state_e        state;
   logic              idle, lookup_hit, hit_now, miss_start, fill_done;

   dmc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
      .addr(cpu_addr), .idx(idx), .tag(tag)
   );

   dmc_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
      .rd_tag(rd_tag), .rd_data(rd_data),
      .wr_en(wr_en), .wr_idx(idx), .wr_tag(tag),
      .wr_data(merged), .wr_dirty(cpu_we)
   );

   dmc_miss_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .miss_start(miss_start),
      .victim_dirty(rd_valid && rd_dirty), .mem_ack(mem_ack), .state(state)
   );

   assign idle       = (state == ST_IDLE);
   assign lookup_hit = rd_valid && (rd_tag == tag);
   assign hit_now    = cpu_req && idle && lookup_hit;
   assign miss_start = cpu_req && idle && !lookup_hit;
   assign fill_done  = (state == ST_FILL) && mem_ack;
   assign cpu_stall  = cpu_req && !(idle && lookup_hit);
   assign cpu_rdata  = rd_data;

   assign wr_en     = (hit_now && cpu_we) || fill_done;
   assign base_word = fill_done ? mem_rdata : rd_data;
   assign eff_be    = cpu_we ? cpu_be : '0;

   for (genvar b = 0; b < BE_W; b++) begin : g_merge
      assign merged[b*8 +: 8] = eff_be[b] ? cpu_wdata[b*8 +: 8] : base_word[b*8 +: 8];
   end

   assign mem_req   = !idle;
   assign mem_we    = (state == ST_WBACK);
   assign mem_addr  = mem_we ? {rd_tag, idx, {OFF_W{1'b0}}} : {tag, idx, {OFF_W{1'b0}}};
   assign mem_wdata = rd_data;

   a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   a_r6_wback_dirty_only: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> rd_valid && rd_dirty);

   a_r6_wback_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ack |=> mem_req && !mem_we &&
      (mem_addr[OFF_W +: IDX_W] == $past(mem_addr[OFF_W +: IDX_W])));

   a_r9_fill_completes: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we && mem_ack && cpu_req |=> !cpu_req || !cpu_stall);

   a_r4_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_stall |-> !mem_req);
endmodule

// File: tb/test_dm_wb_cache.sv
module test_dm_wb_cache;
   localparam int PERIOD = 10;
   localparam int LAT    = 3;

   typedef struct packed {
      logic        we;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [3:0]  be;
      logic        chk;
      logic [31:0] exp_rd;
      logic [7:0]  exp_stall;
      logic        exp_wb;
      logic [31:0] wb_addr;
      logic [31:0] wb_data;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 32'h0000_1004, 32'h0, 4'h0, 1'b1, 32'hFFFF_EFFB, 8'd5, 1'b0, 32'h0, 32'h0},
      '{1'b0, 32'h0000_1004, 32'h0, 4'h0, 1'b1, 32'hFFFF_EFFB, 8'd0, 1'b0, 32'h0, 32'h0},
      '{1'b1, 32'h0000_1004, 32'h1122_3344, 4'hF, 1'b0, 32'h0, 8'd0, 1'b0, 32'h0, 32'h0},
      '{1'b0, 32'h0000_1004, 32'h0, 4'h0, 1'b1, 32'h1122_3344, 8'd0, 1'b0, 32'h0, 32'h0},
      '{1'b1, 32'h0000_1004, 32'hAABB_CCDD, 4'h3, 1'b0, 32'h0, 8'd0, 1'b0, 32'h0, 32'h0},
      '{1'b0, 32'h0000_1004, 32'h0, 4'h0, 1'b1, 32'h1122_CCDD, 8'd0, 1'b0, 32'h0, 32'h0},
      '{1'b0, 32'h0000_2004, 32'h0, 4'h0, 1'b1, 32'hFFFF_DFFB, 8'd9, 1'b1, 32'h0000_1004, 32'h1122_CCDD},
      '{1'b0, 32'h0000_1004, 32'h0, 4'h0, 1'b1, 32'h1122_CCDD, 8'd5, 1'b0, 32'h0, 32'h0},
      '{1'b1, 32'h0000_3008, 32'h7700_0000, 4'h8, 1'b0, 32'h0, 8'd5, 1'b0, 32'h0, 32'h0},
      '{1'b0, 32'h0000_3008, 32'h0, 4'h0, 1'b1, 32'h77FF_CFF7, 8'd0, 1'b0, 32'h0, 32'h0},
      '{1'b0, 32'h0000_4008, 32'h0, 4'h0, 1'b1, 32'hFFFF_BFF7, 8'd9, 1'b1, 32'h0000_3008, 32'h77FF_CFF7},
      '{1'b0, 32'h0000_1006, 32'h0, 4'h0, 1'b1, 32'h1122_CCDD, 8'd0, 1'b0, 32'h0, 32'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [3:0]  cpu_be = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_stall;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;

   dm_wb_cache i_dm_wb_cache (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
      .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   always #(PERIOD/2) clk = ~clk;

   // next-level memory model: untouched words read as the inverted address
   logic [31:0] bmem [logic [31:0]];
   int          cnt = 0;
   int          wb_cnt = 0, fill_cnt = 0, viol = 0;
   logic [31:0] last_wb_addr = '0, last_wb_data = '0;
   logic        prev_pend = 1'b0;
   logic [31:0] prev_addr = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         cnt = 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (cnt == LAT - 1) begin
            cnt = 0;
            mem_ack <= 1'b1;
            if (mem_we) begin
               bmem[mem_addr] = mem_wdata;
               wb_cnt++;
               last_wb_addr = mem_addr;
               last_wb_data = mem_wdata;
            end else begin
               mem_rdata <= bmem.exists(mem_addr) ? bmem[mem_addr] : ~mem_addr;
               fill_cnt++;
            end
         end else begin
            cnt++;
         end
      end
      if (rst_n && prev_pend && mem_req && mem_addr != prev_addr) viol++;
      if (rst_n && mem_req && mem_addr[1:0] != 2'b00) viol++;
      prev_pend <= rst_n && mem_req && !mem_ack;
      prev_addr <= mem_addr;
   end

   task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                         input logic [3:0] be, output logic [31:0] rd, output int stalls);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_be = be;
      stalls = 0;
      #1;
      while (cpu_stall && stalls < 200) begin
         stalls++;
         @(negedge clk);
         #1;
      end
      rd = cpu_rdata;
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   initial begin
      #(PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int          st, wb0, fl0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: idle after reset, no traffic, no stall
      check(!cpu_stall && !mem_req, "R1 reset idle", {30'd0, cpu_stall, mem_req}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         wb0 = wb_cnt; fl0 = fill_cnt;
         access(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].be, rd, st);
         // R1 R5 R9: stall length (0 hit, 5 clean miss, 9 dirty miss)
         check(st == int'(VECS[i].exp_stall), $sformatf("R9 stall cycles vec %0d", i),
               st, VECS[i].exp_stall);
         // R5 R8: one fill per miss, none on a hit (R4 R7)
         check(fill_cnt - fl0 == (VECS[i].exp_stall != 0 ? 1 : 0),
               $sformatf("R5 R8 fill count vec %0d", i), fill_cnt - fl0, VECS[i].exp_stall != 0);
         // R6 R10: write-back only for modified victims
         check(wb_cnt - wb0 == int'(VECS[i].exp_wb), $sformatf("R6 R10 writeback count vec %0d", i),
               wb_cnt - wb0, VECS[i].exp_wb);
         if (VECS[i].exp_wb) begin
            check(last_wb_addr == VECS[i].wb_addr, $sformatf("R6 R2 victim address vec %0d", i),
                  last_wb_addr, VECS[i].wb_addr);
            check(last_wb_data == VECS[i].wb_data, $sformatf("R6 R7 R8 victim data vec %0d", i),
                  last_wb_data, VECS[i].wb_data);
         end
         if (VECS[i].chk)
            check(rd == VECS[i].exp_rd, $sformatf("R4 R7 R8 R2 read data vec %0d", i),
                  rd, VECS[i].exp_rd);
      end

      // R1: modified line is forgotten across reset
      access(1'b1, 32'h0000_4008, 32'hCAFE_F00D, 4'hF, rd, st);
      check(st == 0, "R7 write hit before reset", st, 0);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      wb0 = wb_cnt; fl0 = fill_cnt;
      access(1'b0, 32'h0000_5008, 32'h0, 4'h0, rd, st);
      check(st == 5, "R1 miss after reset stall", st, 5);
      check(wb_cnt == wb0, "R1 no writeback after reset", wb_cnt - wb0, 0);
      check(rd == 32'hFFFF_AFF7, "R1 fill data after reset", rd, 32'hFFFF_AFF7);

      // R3: request stability and alignment over the whole run
      check(viol == 0, "R3 memory request held and aligned", viol, 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule